// File: doc/BRIEF.md
# Copy DMA address generator for a video controller

This block sequences the memory-to-video copy mode of a video controller's DMA engine. Software loads a 16-bit word count and a word-granular source address, split over three byte-wide setup registers. It then starts a transfer, giving a destination byte address, a target memory and an auto-increment step. The block fetches one source word at a time over a simple request/valid read bus. It issues one destination write per returned word, to video RAM, colour RAM or vertical-scroll RAM.

Only the low 16 bits of the source word address count during a copy. The source therefore wraps inside a 128 KB window while its top bits stay frozen. Video RAM addresses wrap at 64 KB. The two small memories see only the low 7 bits of the destination. When a copy ends, the setup registers and the destination pointer stay advanced. A second copy that rewrites only the low length byte continues where the first one stopped, and a later data write can follow on directly after the block.

Top module: `vdma_copy_agen`

## Requirements
- R1: After reset, busy, rd_req and wr_en are low, and dst_addr, the setup registers and the output registers are zero.
- R2: A setup write with cfg_sel 2, 3 or 4 loads source word-address bits 7:0, 15:8 or 21:16 (low bits of cfg_wdata). rd_addr is the concatenation of those three fields.
- R3: After each word read, the low 16 bits of the source address increment modulo 65536. Bits 21:16 never change during a copy.
- R4: cfg_sel 0 and 1 load the low and high byte of the 16-bit word count. A count of zero moves 65536 words.
- R5: Only one read is outstanding. rd_req stays high with rd_addr stable until rd_valid is seen. The next cycle has wr_en high with wr_data equal to the returned word and rd_req low.
- R6: The destination starts at start_dst and advances by auto_inc after every word. For target 0 (video RAM) wr_addr is the full pointer, which wraps modulo 65536.
- R7: For target 1 (colour RAM) and targets 2 or 3 (vertical-scroll RAM), wr_addr is the pointer's low 7 bits with the upper bits zero, so writes wrap at 0x80.
- R8: After a copy the source registers point one word past the last word read and the count registers are zero. A new start that rewrites only the low count byte continues from there.
- R9: After a copy, dst_addr holds the start address plus the word count times auto_inc, modulo 65536.
- R10: busy goes high the cycle after an accepted start and falls after the last write cycle. Setup writes and start pulses while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 3 | Setup register select (0/1 count, 2/3/4 source) |
| cfg_wdata | input | 8 | Setup write data |
| auto_inc | input | INC_W | Destination step per word, in bytes |
| start | input | 1 | Start a copy (sampled while idle) |
| start_dst | input | DST_W | Destination byte address for the copy |
| start_tgt | input | 2 | Target memory code |
| busy | output | 1 | Copy in progress |
| rd_req | output | 1 | Source read request |
| rd_addr | output | SRC_W | Source word address |
| rd_valid | input | 1 | Read data valid for the pending request |
| rd_data | input | DATA_W | Read data |
| wr_en | output | 1 | Destination write strobe |
| wr_tgt | output | 2 | Target memory of the write |
| wr_addr | output | DST_W | Destination byte address of the write |
| wr_data | output | DATA_W | Destination write data |
| dst_addr | output | DST_W | Current destination pointer |

## Verification
A wrong source counter shows up on the very next destination write, because the bench memory returns a word derived from the address it was asked for. A bad carry into the frozen top field is therefore caught on the first word past the window edge. A wrong destination pointer or target mask is seen in wr_addr on the same write. A wrong count shows up as a missing or surplus write when busy falls, and a stale pointer or setup register shows up in dst_addr or in the first write of the chained copy that follows.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} vdma_st_t;

  localparam logic [2:0] SEL_LEN_LO  = 3'd0;
  localparam logic [2:0] SEL_LEN_HI  = 3'd1;
  localparam logic [2:0] SEL_SRC_LO  = 3'd2;
  localparam logic [2:0] SEL_SRC_MID = 3'd3;
  localparam logic [2:0] SEL_SRC_HI  = 3'd4;

  localparam logic [1:0] TGT_VRAM  = 2'd0;
  localparam logic [1:0] TGT_CRAM  = 2'd1;
  localparam logic [1:0] TGT_VSRAM = 2'd2;
endpackage

// File: rtl/vdma_src_addr.sv
module vdma_src_addr #(
  parameter int SRC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [7:0]       wdata,
  input  logic             step,
  output logic [SRC_W-1:0] addr
);
  import vdma_pkg::*;
  localparam int HI_W = SRC_W - 16;

  logic [7:0]      lo_q, mid_q;
  logic [HI_W-1:0] hi_q;

  // Only the 16-bit window counts; the top field is frozen during a copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else if (step) begin
      {mid_q, lo_q} <= {mid_q, lo_q} + 16'd1;
    end else if (we) begin
      case (sel)
        SEL_SRC_LO:  lo_q  <= wdata;
        SEL_SRC_MID: mid_q <= wdata;
        SEL_SRC_HI:  hi_q  <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign addr = {hi_q, mid_q, lo_q};
endmodule

// File: rtl/vdma_len_count.sv
module vdma_len_count (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  input  logic       step,
  output logic       last
);
  import vdma_pkg::*;

  logic [7:0] lo_q, hi_q;

  // The count itself is decremented, so it reads zero after a copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (step) begin
      {hi_q, lo_q} <= {hi_q, lo_q} - 16'd1;
    end else if (we) begin
      case (sel)
        SEL_LEN_LO: lo_q <= wdata;
        SEL_LEN_HI: hi_q <= wdata;
        default: ;
      endcase
    end
  end

  // Zero decrements to 0xFFFF, giving 65536 words.
  assign last = ({hi_q, lo_q} == 16'd1);
endmodule

// File: rtl/vdma_dst_addr.sv
module vdma_dst_addr #(
  parameter int DST_W   = 16,
  parameter int INC_W   = 8,
  parameter int SMALL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DST_W-1:0] load_val,
  input  logic             step,
  input  logic [INC_W-1:0] inc,
  input  logic [1:0]       tgt,
  output logic [DST_W-1:0] ptr,
  output logic [DST_W-1:0] wr_addr
);
  import vdma_pkg::*;

  logic [DST_W-1:0] small_addr;

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + DST_W'(inc);
  end

  generate
    if (SMALL_W < DST_W) begin : g_mask
      assign small_addr = {{(DST_W-SMALL_W){1'b0}}, ptr[SMALL_W-1:0]};
    end else begin : g_full
      assign small_addr = ptr;
    end
  endgenerate

  assign wr_addr = (tgt == TGT_VRAM) ? ptr : small_addr;
endmodule

// File: rtl/vdma_copy_agen.sv
module vdma_copy_agen #(
  parameter int SRC_W   = 22,
  parameter int DST_W   = 16,
  parameter int DATA_W  = 16,
  parameter int INC_W   = 8,
  parameter int SMALL_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [INC_W-1:0]  auto_inc,
  input  logic              start,
  input  logic [DST_W-1:0]  start_dst,
  input  logic [1:0]        start_tgt,
  output logic              busy,
  output logic              rd_req,
  output logic [SRC_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [1:0]        wr_tgt,
  output logic [DST_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DST_W-1:0]  dst_addr
);
  import vdma_pkg::*;

  vdma_st_t         st_q;
  logic [1:0]       tgt_q;
  logic             last_q;
  logic             cfg_ok, start_ok, step, last;
  logic [DST_W-1:0] dst_wa;

  assign cfg_ok   = cfg_we && !busy;
  assign start_ok = start && (st_q == ST_IDLE);
  assign step     = (st_q == ST_RD) && rd_valid;

  vdma_src_addr #(.SRC_W(SRC_W)) u_src (
    .clk(clk), .rst(rst), .we(cfg_ok), .sel(cfg_sel), .wdata(cfg_wdata),
    .step(step), .addr(rd_addr)
  );

  vdma_len_count u_len (
    .clk(clk), .rst(rst), .we(cfg_ok), .sel(cfg_sel), .wdata(cfg_wdata),
    .step(step), .last(last)
  );

  vdma_dst_addr #(.DST_W(DST_W), .INC_W(INC_W), .SMALL_W(SMALL_W)) u_dst (
    .clk(clk), .rst(rst), .load(start_ok), .load_val(start_dst),
    .step(step), .inc(auto_inc), .tgt(tgt_q), .ptr(dst_addr), .wr_addr(dst_wa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      busy    <= 1'b0;
      rd_req  <= 1'b0;
      wr_en   <= 1'b0;
      wr_tgt  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      tgt_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q   <= ST_RD;
          busy   <= 1'b1;
          rd_req <= 1'b1;
          tgt_q  <= start_tgt;
        end
        ST_RD: if (rd_valid) begin
          rd_req  <= 1'b0;
          wr_en   <= 1'b1;
          wr_tgt  <= tgt_q;
          wr_addr <= dst_wa;
          wr_data <= rd_data;
          last_q  <= last;
          st_q    <= ST_WR;
        end
        ST_WR: if (last_q) begin
          st_q <= ST_IDLE;
          busy <= 1'b0;
        end else begin
          st_q   <= ST_RD;
          rd_req <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vdma_copy_agen_chk.sv
module vdma_copy_agen_chk #(
  parameter int SRC_W   = 22,
  parameter int DST_W   = 16,
  parameter int DATA_W  = 16,
  parameter int SMALL_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_req,
  input logic [SRC_W-1:0]  rd_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic [1:0]        wr_tgt,
  input logic [DST_W-1:0]  wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req) && !$past(rd_valid)) |-> $stable(rd_addr));

  p_write_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> (wr_en && !rd_req && wr_data == $past(rd_data)));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_req);

  p_busy_cover_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_req) |-> busy);

  p_win_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (rd_addr[SRC_W-1:16] == $past(rd_addr[SRC_W-1:16])));

  p_small_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tgt != 2'd0) |-> (wr_addr[DST_W-1:SMALL_W] == '0));
endmodule

bind vdma_copy_agen vdma_copy_agen_chk #(
  .SRC_W(SRC_W), .DST_W(DST_W), .DATA_W(DATA_W), .SMALL_W(SMALL_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en), .wr_tgt(wr_tgt),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_vdma_copy_agen.sv
module sim_vdma_copy_agen;
  import vdma_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  auto_inc = 8'd2;
  logic        start = 1'b0;
  logic [15:0] start_dst = '0;
  logic [1:0]  start_tgt = '0;
  logic        busy, rd_req, rd_valid, wr_en;
  logic [21:0] rd_addr;
  logic [15:0] rd_data, wr_addr, wr_data, dst_addr;
  logic [1:0]  wr_tgt;

  always #2 clk = ~clk;

  vdma_copy_agen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .auto_inc(auto_inc), .start(start), .start_dst(start_dst), .start_tgt(start_tgt),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .dst_addr(dst_addr)
  );

  // Source memory model: the word is a function of its address.
  function automatic logic [15:0] fmem(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h2A5};
  endfunction

  logic fast = 1'b0;
  logic sv = 1'b0, served = 1'b0;
  int   lat_cnt = 0;
  localparam int LAT = 2;
  assign rd_data  = fmem(rd_addr);
  assign rd_valid = fast ? rd_req : sv;

  always @(posedge clk) begin
    if (!rd_req || fast) begin
      sv <= 1'b0; served <= 1'b0; lat_cnt <= 0;
    end else if (sv) begin
      sv <= 1'b0; served <= 1'b1;
    end else if (!served) begin
      if (lat_cnt == LAT) sv <= 1'b1;
      else lat_cnt <= lat_cnt + 1;
    end
  end

  int checks = 0, errors = 0;
  string cur_req = "R5";

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {logic [1:0] t; logic [15:0] a; logic [15:0] d;} exp_t;
  exp_t q[$];
  int   wr_cnt = 0;

  // Monitor: pop and compare each destination write.
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      wr_cnt++;
      if (q.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected write"}, {14'd0, wr_tgt, wr_addr}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(wr_tgt == e.t && wr_addr == e.a && wr_data == e.d, cur_req,
            {wr_tgt, wr_addr[13:0], wr_data}, {e.t, e.a[13:0], e.d});
      end
    end
  end

  // Reference state of the setup registers and destination pointer.
  logic [21:0] m_src = '0;
  logic [15:0] m_len = '0;
  logic [15:0] m_dst = '0;

  task automatic raw_cfg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] s, input logic [7:0] v);
    raw_cfg(s, v);
    case (s)
      SEL_LEN_LO:  m_len[7:0]   = v;
      SEL_LEN_HI:  m_len[15:8]  = v;
      SEL_SRC_LO:  m_src[7:0]   = v;
      SEL_SRC_MID: m_src[15:8]  = v;
      SEL_SRC_HI:  m_src[21:16] = v[5:0];
      default: ;
    endcase
  endtask

  int exp_words = 0;

  task automatic kick(input logic [15:0] d, input logic [1:0] t, input logic [7:0] inc,
                      input bit f);
    exp_t e;
    int n;
    n = (m_len == 16'd0) ? 65536 : int'(m_len);
    exp_words = n;
    m_dst = d;
    for (int i = 0; i < n; i++) begin
      e.t = t;
      e.a = (t == TGT_VRAM) ? m_dst : {9'd0, m_dst[6:0]};
      e.d = fmem(m_src);
      q.push_back(e);
      m_src[15:0] = m_src[15:0] + 16'd1;
      m_dst = m_dst + {8'd0, inc};
    end
    m_len = '0;
    wr_cnt = 0;
    @(negedge clk);
    fast = f; auto_inc = inc; start_dst = d; start_tgt = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    chk(q.size() == 0, "R4 words left", q.size(), 0);
    chk(wr_cnt == exp_words, "R4 word count", wr_cnt, exp_words);
    chk(dst_addr == m_dst, "R9 destination pointer", {16'd0, dst_addr}, {16'd0, m_dst});
    chk(!rd_req && !wr_en, "R10 idle outputs", {30'd0, rd_req, wr_en}, 32'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !rd_req && !wr_en, "R1 control low", {29'd0, busy, rd_req, wr_en}, 32'd0);
    chk(dst_addr == 16'd0 && rd_addr == 22'd0, "R1 registers zero",
        {10'd0, rd_addr}, 32'd0);

    // R2, R6: plain video RAM copy with read latency
    cur_req = "R2 R6 basic copy";
    cfg(SEL_LEN_LO, 8'd4); cfg(SEL_LEN_HI, 8'd0);
    cfg(SEL_SRC_LO, 8'h34); cfg(SEL_SRC_MID, 8'h12); cfg(SEL_SRC_HI, 8'h05);
    @(negedge clk);
    chk(rd_addr == 22'h051234, "R2 source composition", {10'd0, rd_addr}, 32'h051234);
    kick(16'h0100, TGT_VRAM, 8'd2, 1'b0);
    wait_done();

    // R8: chained copy, only low count rewritten
    cur_req = "R8 chained copy";
    chk(rd_addr == 22'h051238, "R8 source advanced", {10'd0, rd_addr}, 32'h051238);
    cfg(SEL_LEN_LO, 8'd3);
    kick(16'h0200, TGT_VRAM, 8'd2, 1'b0);
    wait_done();

    // R3: source crosses the window edge
    cur_req = "R3 source window wrap";
    cfg(SEL_SRC_LO, 8'hFE); cfg(SEL_SRC_MID, 8'hFF); cfg(SEL_SRC_HI, 8'h2A);
    cfg(SEL_LEN_LO, 8'd4);
    kick(16'h0400, TGT_VRAM, 8'd2, 1'b0);
    wait_done();
    chk(rd_addr == 22'h2A0002, "R3 top field frozen", {10'd0, rd_addr}, 32'h2A0002);

    // R6: video RAM destination wraps, odd step
    cur_req = "R6 destination wrap";
    cfg(SEL_LEN_LO, 8'd5);
    kick(16'hFFFC, TGT_VRAM, 8'd3, 1'b1);
    wait_done();

    // R7: colour RAM with high address bits set
    cur_req = "R7 colour RAM wrap";
    cfg(SEL_LEN_LO, 8'd4);
    kick(16'hFFFD, TGT_CRAM, 8'd2, 1'b0);
    wait_done();

    // R7: vertical-scroll RAM, 0x48 bytes from 0x3C
    cur_req = "R7 scroll RAM wrap";
    cfg(SEL_LEN_LO, 8'h24);
    kick(16'h003C, TGT_VSRAM, 8'd2, 1'b1);
    wait_done();

    // R10: setup writes and a start during a copy are ignored
    cur_req = "R10 ignore while busy";
    cfg(SEL_LEN_LO, 8'd6);
    kick(16'h0800, TGT_VRAM, 8'd2, 1'b0);
    raw_cfg(SEL_LEN_LO, 8'd5);
    raw_cfg(SEL_SRC_LO, 8'h77);
    @(negedge clk);
    start_dst = 16'h3000; start_tgt = TGT_CRAM; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    cur_req = "R10 R8 source kept";
    cfg(SEL_LEN_LO, 8'd2);
    kick(16'h0900, TGT_VRAM, 8'd2, 1'b0);
    wait_done();

    // R4, R8: count left at zero means 65536 words
    cur_req = "R4 zero count";
    kick(16'h0100, TGT_VRAM, 8'd2, 1'b1);
    wait_done();

    summary();
    $finish;
  end
endmodule